// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave

This block is the two-wire serial target that holds the configuration image of a programmable clock generator. SCL and SDA are brought into the system clock domain through short synchroniser chains. Start and stop conditions are recognised there. The block answers a single fixed 7-bit device address. After the address byte it takes an 8-bit register pointer and then either stores incoming bytes or returns stored bytes. The pointer advances by one after every byte, in both directions.

A read begins with a write that carries only the pointer. It is followed by a repeated start carrying the read bit, after which the slave sends consecutive registers. The master acknowledges each byte it receives and ends the burst with a not-acknowledge. Only eleven locations hold state. Every other address accepts writes without storing them and reads back as zero. Some bit positions in three of the registers hold mandatory values, which are imposed on every write.

The parallel side reads the image through a combinational address/data port. The reset image is all zeros, which leaves every clock output of the generator disabled.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The slave acknowledges only the device byte whose upper seven bits are 1101001 (byte D2h for write, D3h for read). Any other device byte gets no acknowledge and the rest of that transaction is ignored until the next start.
- R2: In a write transaction, the byte after the device byte loads the register pointer. Each following data byte is stored at the pointer, and the pointer then increments by one.
- R3: The slave pulls SDA low for the whole ninth SCL clock of every byte it accepts: the matching device byte, the pointer byte and each data byte. Its SDA drive changes only while SCL is low.
- R4: After a pointer write and a repeated start with the read bit set, the slave sends the registers at the pointer, pointer+1 and so on, most significant bit first. Each master acknowledge requests the next byte. A master not-acknowledge ends the burst and leaves SDA released.
- R5: The pointer wraps from FFh to 00h, both when writing and when reading.
- R6: After reset, SDA is released and every register reads 00h.
- R7: Only addresses 09h, 0Ch, 12h, 13h, 40h, 41h, 42h, 44h, 45h, 46h and 47h hold data. A write to any other address is acknowledged and discarded, and that address reads 00h.
- R8: On every write, register 12h gets bits 7..5 = 001 and bits 2..0 = 000, register 40h gets bits 7..5 = 110, and register 46h gets bits 5..0 = 111111. The remaining bits take the written value.
- R9: A stop or start seen before the eighth bit of a byte is complete aborts that byte, and nothing is stored. A stop returns the slave to idle. A start makes it wait for a new device byte.
- R10: cfgData presents, combinationally, the stored value of the register selected by cfgAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaPullLow | output | 1 | High when the slave pulls SDA low (open-drain control) |
| cfgAddr | input | 8 | Parallel read address into the register image |
| cfgData | output | 8 | Register value at cfgAddr |

## Verification
An SCL edge takes two synchroniser cycles and one edge-detect cycle to become an event. The acknowledge drive and each read data bit therefore change about three cycles after SCL falls, and a stored byte appears on cfgData one cycle after that. The bench holds each SCL phase for eight system cycles and samples SDA in the middle of the high phase, so every bus result is well settled when it is read. Parallel-port checks are made only after the stop condition plus idle time. The pointer-step, strobe and fixed-bit properties are checked each cycle from a bound checker.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NUM_REGS = 11;

  localparam logic [7:0] REG_ADDR [NUM_REGS] = '{
    8'h09, 8'h0C, 8'h12, 8'h13, 8'h40, 8'h41,
    8'h42, 8'h44, 8'h45, 8'h46, 8'h47
  };

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_REG, PH_WR, PH_RD
  } phase_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       ptrLoad;
    logic       dataWr;
    logic       ptrInc;
    logic [7:0] byteVal;
  } strobe_t;

  function automatic logic isImplemented(input logic [7:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (REG_ADDR[i] == a) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [7:0] fixMask(input logic [7:0] a);
    case (a)
      8'h12:   return 8'hE7;
      8'h40:   return 8'hE0;
      8'h46:   return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] fixVal(input logic [7:0] a);
    case (a)
      8'h12:   return 8'h20;
      8'h40:   return 8'hC0;
      8'h46:   return 8'h3F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [7:0] curData,
  output logic       sdaPullLow,
  output strobe_t    stb
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(8);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(9);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, startSeen, stopSeen;

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic             rwBit;
  logic             mstNak;
  logic             sdaDrv;
  logic             fallAtAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign fallAtAck = sclFall && (bitCnt == ACK_CNT) && (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      rwBit   <= 1'b0;
      mstNak  <= 1'b0;
      sdaDrv  <= 1'b0;
    end else if (startSeen) begin
      phase  <= PH_DEV;
      bitCnt <= '0;
      sdaDrv <= 1'b0;
    end else if (stopSeen) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      sdaDrv <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (sclRise) begin
        if (phase == PH_RD) begin
          if (bitCnt == ACK_CNT) mstNak <= sdaNow;
        end else if (bitCnt < ACK_CNT) begin
          rxShift <= {rxShift[6:0], sdaNow};
        end
        if (bitCnt != DONE_CNT) bitCnt <= bitCnt + 1'b1;
      end else if (sclFall) begin
        if (bitCnt == ACK_CNT) begin
          if (phase == PH_RD) begin
            sdaDrv <= 1'b0;
          end else if (phase == PH_DEV && rxShift[7:1] != DEV_ADDR) begin
            phase  <= PH_IDLE;
            bitCnt <= '0;
          end else begin
            sdaDrv <= 1'b1;
            if (phase == PH_DEV) rwBit <= rxShift[0];
          end
        end else if (bitCnt == DONE_CNT) begin
          bitCnt <= '0;
          sdaDrv <= 1'b0;
          case (phase)
            PH_DEV: begin
              if (rwBit) begin
                phase   <= PH_RD;
                txShift <= curData;
                sdaDrv  <= ~curData[7];
              end else begin
                phase <= PH_REG;
              end
            end
            PH_REG:  phase <= PH_WR;
            PH_WR:   phase <= PH_WR;
            PH_RD: begin
              if (mstNak) begin
                phase <= PH_IDLE;
              end else begin
                txShift <= curData;
                sdaDrv  <= ~curData[7];
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end else if (phase == PH_RD && bitCnt != '0) begin
          txShift <= {txShift[6:0], 1'b0};
          sdaDrv  <= ~txShift[6];
        end
      end
    end
  end

  always_comb begin
    stb.ptrLoad = fallAtAck && (phase == PH_REG);
    stb.dataWr  = fallAtAck && (phase == PH_WR);
    stb.ptrInc  = fallAtAck && (phase == PH_RD);
    stb.byteVal = rxShift;
  end

  assign sdaPullLow = sdaDrv;

endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:0] cfgAddr,
  output logic [7:0] cfgData,
  output logic [7:0] curData,
  output logic [7:0] ptrVal
);

  logic [7:0] ptr;
  logic [7:0] regFile [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.ptrLoad) begin
      ptr <= stb.byteVal;
    end else if (stb.dataWr || stb.ptrInc) begin
      ptr <= ptr + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (stb.dataWr) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ptr == REG_ADDR[i])
          regFile[i] <= (stb.byteVal & ~fixMask(REG_ADDR[i])) | fixVal(REG_ADDR[i]);
    end
  end

  always_comb begin
    cfgData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (cfgAddr == REG_ADDR[i]) cfgData = regFile[i];
  end

  always_comb begin
    curData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == REG_ADDR[i]) curData = regFile[i];
  end

  assign ptrVal = ptr;

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  input  logic [7:0] cfgAddr,
  output logic [7:0] cfgData
);

  strobe_t    ctrlStb;
  logic [7:0] curData;
  logic [7:0] ptrVal;

  clkcfg_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaIn),
    .curData   (curData),
    .sdaPullLow(sdaPullLow),
    .stb       (ctrlStb)
  );

  clkcfg_regs regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (ctrlStb),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .curData(curData),
    .ptrVal (ptrVal)
  );

endmodule

// File: rtl/clkcfg_checker.sv
module clkcfg_checker
  import clkcfg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       scl,
  input logic       sdaPullLow,
  input logic [7:0] cfgAddr,
  input logic [7:0] cfgData,
  input strobe_t    ctrlStb,
  input logic [7:0] ptrVal
);

  a_r3_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !scl);

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.ptrLoad |=> ptrVal == $past(ctrlStb.byteVal));

  a_r5_write_step_wraps: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.dataWr |=> ptrVal == 8'($past(ptrVal) + 8'd1));

  a_r4_read_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.ptrInc |=> ptrVal == 8'($past(ptrVal) + 8'd1));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlStb.ptrLoad, ctrlStb.dataWr, ctrlStb.ptrInc}));

  a_r7_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isImplemented(cfgAddr) |-> cfgData == 8'h00);

  a_r8_fixed_12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h12 && cfgData != 8'h00) |-> (cfgData & 8'hE7) == 8'h20);

  a_r8_fixed_40: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h40 && cfgData != 8'h00) |-> cfgData[7:5] == 3'b110);

  a_r8_fixed_46: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h46 && cfgData != 8'h00) |-> cfgData[5:0] == 6'h3F);

endmodule

bind clkgen_cfg_slave clkcfg_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .scl       (scl),
  .sdaPullLow(sdaPullLow),
  .cfgAddr   (cfgAddr),
  .cfgData   (cfgData),
  .ctrlStb   (ctrlStb),
  .ptrVal    (ptrVal)
);

// File: tb/clkgen_cfg_slave_tb_top.sv
module clkgen_cfg_slave_tb_top;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       sdaMst = 1'b1;
  logic       sdaLine;
  logic       sdaPullLow;
  logic [7:0] cfgAddr = 8'h00;
  logic [7:0] cfgData;

  int testsRun = 0;
  int testsFailed = 0;

  string      expTag[$];
  logic [7:0] expVal[$];
  logic [7:0] gotVal[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaMst & ~sdaPullLow;

  clkgen_cfg_slave dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaLine),
    .sdaPullLow(sdaPullLow),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (gotVal.size() != 0 && expVal.size() != 0);
      check(expTag.pop_front(), gotVal.pop_front(), expVal.pop_front());
    end
  end

  task automatic busStart();
    sdaMst = 1'b1; waitClk(HALF);
    scl = 1'b1;    waitClk(HALF);
    sdaMst = 1'b0; waitClk(HALF);
    scl = 1'b0;    waitClk(HALF);
  endtask

  task automatic busStop();
    sdaMst = 1'b0; waitClk(HALF);
    scl = 1'b1;    waitClk(HALF);
    sdaMst = 1'b1; waitClk(4 * HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaMst = b[i]; waitClk(HALF);
      scl = 1'b1;    waitClk(HALF);
      scl = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag, input logic expAck);
    logic ack;
    expTag.push_back(tag);
    expVal.push_back({7'd0, expAck});
    sendBits(b, 8);
    sdaMst = 1'b1; waitClk(HALF);
    scl = 1'b1;    waitClk(HALF / 2);
    ack = ~sdaLine;
    waitClk(HALF / 2);
    scl = 1'b0;
    gotVal.push_back({7'd0, ack});
  endtask

  task automatic recvByte(input logic [7:0] exp, input string tag, input logic mstAck);
    logic [7:0] b;
    expTag.push_back(tag);
    expVal.push_back(exp);
    sdaMst = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      scl = 1'b1; waitClk(HALF / 2);
      b[i] = sdaLine;
      waitClk(HALF / 2);
      scl = 1'b0;
    end
    sdaMst = ~mstAck; waitClk(HALF);
    scl = 1'b1;       waitClk(HALF);
    scl = 1'b0;
    sdaMst = 1'b1;
    gotVal.push_back(b);
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cfgAddr = a;
    waitClk(1);
    check(tag, cfgData, exp);
  endtask

  initial begin
    waitClk(200000 / 4 * 3);
    testsFailed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    waitClk(5);
    // R6: reset image and released SDA
    check("R6 sda released in reset", {7'd0, sdaPullLow}, 8'h00);
    peek(8'h09, 8'h00, "R6 reg 09h after reset");
    peek(8'h46, 8'h00, "R6 reg 46h after reset");
    rstN = 1'b1;
    waitClk(10);

    // R1/R2/R3/R8: burst write 44h..46h
    busStart();
    sendByte(8'hD2, "R1 R3 device ack", 1'b1);
    sendByte(8'h44, "R3 pointer ack", 1'b1);
    sendByte(8'hA1, "R3 data ack 44h", 1'b1);
    sendByte(8'hB2, "R3 data ack 45h", 1'b1);
    sendByte(8'hC0, "R3 data ack 46h", 1'b1);
    busStop();
    peek(8'h44, 8'hA1, "R2 R10 reg 44h");
    peek(8'h45, 8'hB2, "R2 reg 45h");
    peek(8'h46, 8'hFF, "R8 reg 46h forced low bits");

    // R7/R8: fixed bits on 12h, 40h and reserved 43h
    busStart();
    sendByte(8'hD2, "R1 device ack", 1'b1);
    sendByte(8'h12, "R3 pointer ack", 1'b1);
    sendByte(8'hFF, "R3 data ack 12h", 1'b1);
    busStop();
    peek(8'h12, 8'h38, "R8 reg 12h forced bits");
    busStart();
    sendByte(8'hD2, "R1 device ack", 1'b1);
    sendByte(8'h40, "R3 pointer ack", 1'b1);
    sendByte(8'h1F, "R3 data ack 40h", 1'b1);
    sendByte(8'h55, "R3 data ack 41h", 1'b1);
    sendByte(8'h66, "R3 data ack 42h", 1'b1);
    sendByte(8'h77, "R7 reserved 43h still acked", 1'b1);
    sendByte(8'h88, "R3 data ack 44h", 1'b1);
    busStop();
    peek(8'h40, 8'hDF, "R8 reg 40h forced bits");
    peek(8'h42, 8'h66, "R2 reg 42h");
    peek(8'h43, 8'h00, "R7 reserved 43h reads zero");
    peek(8'h44, 8'h88, "R2 reg 44h overwritten");

    // R1: wrong device address is ignored
    busStart();
    sendByte(8'hD4, "R1 foreign address not acked", 1'b0);
    sendByte(8'h41, "R1 pointer ignored", 1'b0);
    sendByte(8'h00, "R1 data ignored", 1'b0);
    busStop();
    peek(8'h41, 8'h55, "R1 reg 41h untouched");

    // R4: read burst via repeated start
    busStart();
    sendByte(8'hD2, "R4 device ack", 1'b1);
    sendByte(8'h41, "R4 pointer ack", 1'b1);
    busStart();
    sendByte(8'hD3, "R4 read device ack", 1'b1);
    recvByte(8'h55, "R4 read 41h", 1'b1);
    recvByte(8'h66, "R4 read 42h", 1'b1);
    recvByte(8'h00, "R7 R4 read reserved 43h", 1'b1);
    recvByte(8'h88, "R4 read 44h", 1'b0);
    check("R4 sda released after nak", {7'd0, sdaPullLow}, 8'h00);
    busStop();

    // R5: pointer wrap on write and read
    busStart();
    sendByte(8'hD2, "R5 device ack", 1'b1);
    sendByte(8'hFF, "R5 pointer ack", 1'b1);
    for (int i = 0; i < 10; i++) sendByte(8'hEE, "R5 wrap data ack", 1'b1);
    sendByte(8'h5A, "R5 data ack 09h", 1'b1);
    busStop();
    peek(8'h09, 8'h5A, "R5 write wrapped to 09h");
    busStart();
    sendByte(8'hD2, "R5 device ack", 1'b1);
    sendByte(8'hFF, "R5 pointer ack", 1'b1);
    busStart();
    sendByte(8'hD3, "R5 read device ack", 1'b1);
    for (int i = 0; i < 10; i++) recvByte(8'h00, "R5 read reserved run", 1'b1);
    recvByte(8'h5A, "R5 read wrapped 09h", 1'b0);
    busStop();

    // R9: stop mid-byte aborts
    busStart();
    sendByte(8'hD2, "R9 device ack", 1'b1);
    sendByte(8'h0C, "R9 pointer ack", 1'b1);
    sendByte(8'h11, "R9 data ack 0Ch", 1'b1);
    sendBits(8'hE6, 4);
    busStop();
    peek(8'h0C, 8'h11, "R9 reg 0Ch after stop abort");
    peek(8'h13, 8'h00, "R9 reg 13h after stop abort");
    // R9: start mid-byte restarts address reception
    busStart();
    sendByte(8'hD2, "R9 device ack", 1'b1);
    sendByte(8'h0C, "R9 pointer ack", 1'b1);
    sendBits(8'h99, 3);
    busStart();
    sendByte(8'hD2, "R9 device ack after restart", 1'b1);
    sendByte(8'h13, "R9 pointer ack after restart", 1'b1);
    sendByte(8'h7E, "R9 data ack 13h", 1'b1);
    busStop();
    peek(8'h13, 8'h7E, "R9 reg 13h written after restart");
    peek(8'h0C, 8'h11, "R9 reg 0Ch untouched by partial byte");

    wait (gotVal.size() == 0);
    waitClk(4);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule